// File: doc/BRIEF.md
# Masked Data Watchpoint Unit

This block watches the data accesses of a processor pipeline against a small set of programmable watchpoints. Each watchpoint holds an address word and a control word. The control word arms the watchpoint for loads, for stores, or for both, and it carries a six-bit mask field. The mask selects a naturally aligned region whose size is a power of two, from 1 to 64 bytes. Every access presented on the access port is compared against all armed watchpoints in the same cycle. A hit is therefore known before the access commits, and the pipeline can suppress the access.

Configuration goes in through two write strobes that share one data bus and one unit select. A mask field whose ones are not contiguous is not rejected. It is cut back to its leading run of ones instead. On a hit the block reports the lowest hitting unit. It also produces a debug-cause update that carries a data-break flag and the unit number.

Top module: `data_watch_unit`

## Requirements
- R1: Control bit 31 arms a unit for stores and control bit 30 arms it for loads. A unit with both bits clear never hits, and a unit armed only for one kind of access ignores the other kind.
- R2: The effective mask is control bits 5:0 with every bit above them forced to 1. The region base is the address word ANDed with the mask, and the region size is (~mask + 1) bytes.
- R3: A mask field whose ones are not contiguous from bit 5 downward is replaced by its leading run of ones. For example, field 6'b101100 acts as 6'b100000, which gives a 32-byte region.
- R4: The access size code selects 1, 2, 4 or 8 bytes for codes 0, 1, 2 and 3. An access hits when any of its bytes lies inside the region, even if its start address lies outside the region.
- R5: A hit is reported combinationally in the same cycle as the access. Nothing hits while acc_valid is low.
- R6: When several units hit the same access, hit_idx gives the lowest unit number.
- R7: cause_we is high exactly when hit is high. While it is high, cause_data bit 0 is 1, bits 7:4 hold the hitting unit number, and all other bits are 0.
- R8: A configuration write is used by accesses from the cycle after its clock edge. The region is refreshed when the address changes on an armed unit, or when the enable bits or mask field change. An address written while a unit is disarmed is therefore used once the unit is armed.
- R9: After reset every unit is disarmed and no access hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_addr | input | 1 | Write strobe for the address word of the selected unit |
| cfg_we_ctrl | input | 1 | Write strobe for the control word of the selected unit |
| cfg_sel | input | SEL_W | Unit select for configuration writes |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | A data access is presented |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | 32 | First byte address of the access |
| acc_size | input | 2 | Log2 of the access size in bytes |
| hit | output | 1 | The access matches at least one armed unit |
| hit_idx | output | SEL_W | Lowest hitting unit number |
| cause_we | output | 1 | Debug-cause update strobe |
| cause_data | output | 8 | Debug-cause value: bit 0 data-break flag, bits 7:4 unit number |

## Verification
The checker module tests the following on every cycle:
- Each reported hit belongs to a unit armed for that kind of access.
- No hit appears without a valid access, or while every unit is disarmed.
- cause_we tracks hit exactly, and the cause fields agree with hit_idx.

Other behaviour only the bench scenarios can show: region size and alignment, trimming of a broken mask, partial overlap by wide accesses, lowest-index priority, and the use of an address written while a unit was disarmed. The bench checks these against a separate address model.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned MASK_W        = 6;
  localparam int unsigned ST_EN_BIT     = 31;
  localparam int unsigned LD_EN_BIT     = 30;
  localparam int unsigned CAUSE_W       = 8;
  localparam int unsigned CAUSE_IDX_LSB = 4;
  localparam int unsigned CAUSE_IDX_W   = CAUSE_W - CAUSE_IDX_LSB;

  typedef struct packed {
    logic ld;
    logic st;
  } arm_t;
endpackage

// File: rtl/dbw_slot.sv
module dbw_slot
  import dbw_pkg::*;
#(
  parameter int unsigned AW = DATA_W,
  parameter int unsigned MW = MASK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_addr,
  input  logic          we_ctrl,
  input  logic [AW-1:0] wdata,
  output arm_t          arm,
  output logic [AW-1:0] reg_lo,
  output logic [AW-1:0] reg_hi
);
  logic [AW-1:0] addr_q, addr_d;
  logic [MW-1:0] fld_q, fld_d;
  arm_t          arm_q, arm_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] mask_q, mask_d;
  logic [MW-1:0] trim;
  logic          refresh;

  // Next-state logic.
  always_comb begin
    addr_d = we_addr ? wdata : addr_q;
    fld_d  = we_ctrl ? wdata[MW-1:0] : fld_q;
    arm_d  = arm_q;
    if (we_ctrl) begin
      arm_d.ld = wdata[LD_EN_BIT];
      arm_d.st = wdata[ST_EN_BIT];
    end
    // Keep only the leading run of ones of the mask field (R3).
    trim[MW-1] = fld_d[MW-1];
    for (int j = MW - 2; j >= 0; j--) begin
      trim[j] = fld_d[j] & trim[j+1];
    end
    // Refresh the region on an enable or mask change, or on an address
    // change while the unit is armed (R8).
    refresh = (we_ctrl && ({arm_d, fld_d} != {arm_q, fld_q})) ||
              (we_addr && (wdata != addr_q) && (arm_d.ld || arm_d.st));
    mask_d  = refresh ? {{(AW-MW){1'b1}}, trim} : mask_q;
    base_d  = refresh ? (addr_d & {{(AW-MW){1'b1}}, trim}) : base_q;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      fld_q  <= '0;
      arm_q  <= '0;
      base_q <= '0;
      mask_q <= '1;
    end else begin
      addr_q <= addr_d;
      fld_q  <= fld_d;
      arm_q  <= arm_d;
      base_q <= base_d;
      mask_q <= mask_d;
    end
  end

  assign arm    = arm_q;
  assign reg_lo = base_q;
  assign reg_hi = base_q | ~mask_q;
endmodule

// File: rtl/dbw_match.sv
module dbw_match #(
  parameter int unsigned AW = 32
) (
  input  logic          acc_valid,
  input  logic          acc_store,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic          arm_ld,
  input  logic          arm_st,
  input  logic [AW-1:0] reg_lo,
  input  logic [AW-1:0] reg_hi,
  output logic          hit
);
  logic [AW:0] a_first;
  logic [AW:0] a_last;
  logic        kind_ok;
  logic        overlap;

  always_comb begin
    a_first = {1'b0, acc_addr};
    a_last  = a_first + ((AW+1)'(1) << acc_size) - (AW+1)'(1);
    kind_ok = acc_store ? arm_st : arm_ld;
    overlap = (a_first <= {1'b0, reg_hi}) && (a_last >= {1'b0, reg_lo});
    hit     = acc_valid && kind_ok && overlap;
  end
endmodule

// File: rtl/dbw_pick.sv
module dbw_pick #(
  parameter int unsigned N  = 2,
  parameter int unsigned IW = 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/data_watch_unit.sv
module data_watch_unit
  import dbw_pkg::*;
#(
  parameter int unsigned NUM_WP = 2,
  parameter int unsigned SEL_W  = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we_addr,
  input  logic               cfg_we_ctrl,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               acc_valid,
  input  logic               acc_store,
  input  logic [DATA_W-1:0]  acc_addr,
  input  logic [1:0]         acc_size,
  output logic               hit,
  output logic [SEL_W-1:0]   hit_idx,
  output logic               cause_we,
  output logic [CAUSE_W-1:0] cause_data
);
  logic [NUM_WP-1:0] unit_hit;

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    arm_t              arm;
    logic [DATA_W-1:0] lo;
    logic [DATA_W-1:0] hi;
    logic              sel_me;

    assign sel_me = (cfg_sel == SEL_W'(g));

    dbw_slot #(.AW(DATA_W), .MW(MASK_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_addr (cfg_we_addr && sel_me),
      .we_ctrl (cfg_we_ctrl && sel_me),
      .wdata   (cfg_wdata),
      .arm     (arm),
      .reg_lo  (lo),
      .reg_hi  (hi)
    );

    dbw_match #(.AW(DATA_W)) u_match (
      .acc_valid (acc_valid),
      .acc_store (acc_store),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .arm_ld    (arm.ld),
      .arm_st    (arm.st),
      .reg_lo    (lo),
      .reg_hi    (hi),
      .hit       (unit_hit[g])
    );
  end

  dbw_pick #(.N(NUM_WP), .IW(SEL_W)) u_pick (
    .req (unit_hit),
    .any (hit),
    .idx (hit_idx)
  );

  always_comb begin
    cause_we   = hit;
    cause_data = '0;
    if (hit) begin
      cause_data[0] = 1'b1;
      cause_data[CAUSE_IDX_LSB +: CAUSE_IDX_W] = CAUSE_IDX_W'(hit_idx);
    end
  end
endmodule

// File: rtl/data_watch_unit_chk.sv
module data_watch_unit_chk
  import dbw_pkg::*;
#(
  parameter int unsigned NUM_WP = 2,
  parameter int unsigned SEL_W  = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we_ctrl,
  input logic [SEL_W-1:0]   cfg_sel,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic               acc_valid,
  input logic               acc_store,
  input logic               hit,
  input logic [SEL_W-1:0]   hit_idx,
  input logic               cause_we,
  input logic [CAUSE_W-1:0] cause_data
);
  logic [NUM_WP-1:0] sh_ld;
  logic [NUM_WP-1:0] sh_st;

  for (genvar g = 0; g < NUM_WP; g++) begin : g_sh
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_ld[g] <= 1'b0;
        sh_st[g] <= 1'b0;
      end else if (cfg_we_ctrl && cfg_sel == SEL_W'(g)) begin
        sh_ld[g] <= cfg_wdata[LD_EN_BIT];
        sh_st[g] <= cfg_wdata[ST_EN_BIT];
      end
    end
  end

  p_arm_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (acc_store ? sh_st[hit_idx] : sh_ld[hit_idx]));

  p_valid_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !hit);

  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(hit_idx) < NUM_WP));

  p_cause_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we == hit);

  p_cause_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |-> (cause_data[0] &&
                  cause_data[CAUSE_IDX_LSB +: CAUSE_IDX_W] == CAUSE_IDX_W'(hit_idx) &&
                  cause_data[CAUSE_IDX_LSB-1:1] == '0));

  p_quiet_disarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sh_ld == '0) && (sh_st == '0)) |-> !hit);
endmodule

bind data_watch_unit data_watch_unit_chk #(.NUM_WP(NUM_WP), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we_ctrl (cfg_we_ctrl),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .acc_valid   (acc_valid),
  .acc_store   (acc_store),
  .hit         (hit),
  .hit_idx     (hit_idx),
  .cause_we    (cause_we),
  .cause_data  (cause_data)
);

// File: tb/data_watch_unit_tb.sv
`timescale 1ns/1ps
module data_watch_unit_tb;
  localparam int NWP = 2;
  localparam int SW  = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we_addr, cfg_we_ctrl;
  logic [SW-1:0] cfg_sel;
  logic [31:0]   cfg_wdata;
  logic          acc_valid, acc_store;
  logic [31:0]   acc_addr;
  logic [1:0]    acc_size;
  logic          hit;
  logic [SW-1:0] hit_idx;
  logic          cause_we;
  logic [7:0]    cause_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] addr_m [NWP];
  logic [31:0] ctrl_m [NWP];

  always #5 clk = ~clk;

  data_watch_unit #(.NUM_WP(NWP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we_addr(cfg_we_addr), .cfg_we_ctrl(cfg_we_ctrl),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_store(acc_store), .acc_addr(acc_addr), .acc_size(acc_size),
    .hit(hit), .hit_idx(hit_idx), .cause_we(cause_we), .cause_data(cause_data)
  );

  function automatic logic [31:0] eff_mask(logic [5:0] f);
    logic [31:0] m;
    int n;
    m = {26'h3FFFFFF, f};
    n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (!m[i]) break;
      n++;
    end
    return (n == 32) ? 32'hFFFFFFFF : (32'hFFFFFFFF << (32 - n));
  endfunction

  function automatic bit unit_hits(int u, logic [31:0] a, logic [1:0] sz, bit st);
    logic [31:0] m, lo, hi;
    longint af, al;
    bit armed;
    armed = st ? ctrl_m[u][31] : ctrl_m[u][30];
    m  = eff_mask(ctrl_m[u][5:0]);
    lo = addr_m[u] & m;
    hi = lo | ~m;
    af = longint'(a);
    al = af + (longint'(1) << sz) - 1;
    return armed && (af <= longint'(hi)) && (al >= longint'(lo));
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(bit is_ctrl, int u, logic [31:0] v);
    @(negedge clk);
    cfg_sel   = SW'(u);
    cfg_wdata = v;
    cfg_we_addr = !is_ctrl;
    cfg_we_ctrl = is_ctrl;
    @(posedge clk);
    #1;
    cfg_we_addr = 1'b0;
    cfg_we_ctrl = 1'b0;
    if (is_ctrl) ctrl_m[u] = v; else addr_m[u] = v;
  endtask

  task automatic access(string tag, bit v, bit st, logic [31:0] a, logic [1:0] sz);
    bit eh;
    int ei;
    @(negedge clk);
    acc_valid = v; acc_store = st; acc_addr = a; acc_size = sz;
    #2;
    eh = 0; ei = 0;
    if (v) begin
      for (int u = NWP - 1; u >= 0; u--) begin
        if (unit_hits(u, a, sz, st)) begin eh = 1; ei = u; end
      end
    end
    chk(tag, "hit", hit, eh);
    if (eh) chk(tag, "hit_idx", hit_idx, ei);
    chk("R7", "cause_we", cause_we, eh);
    chk("R7", "cause_data", cause_data, eh ? ((ei << 4) | 1) : 0);
    acc_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    for (int u = 0; u < NWP; u++) begin addr_m[u] = '0; ctrl_m[u] = '0; end
    rst_n = 1'b0; cfg_we_addr = 0; cfg_we_ctrl = 0; cfg_sel = '0; cfg_wdata = '0;
    acc_valid = 0; acc_store = 0; acc_addr = '0; acc_size = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: reset state, nothing armed
    access("R9", 1, 1, 32'h0, 2'd3);
    access("R9", 1, 0, 32'h0, 2'd0);

    // R1: store-only arming, 4-byte region at 0x1000
    wr(0, 0, 32'h0000_1000);
    wr(1, 0, 32'h8000_003C);
    access("R1", 1, 1, 32'h0000_1002, 2'd0);
    access("R1", 1, 0, 32'h0000_1002, 2'd0);
    wr(1, 0, 32'h4000_003C);
    access("R1", 1, 0, 32'h0000_1003, 2'd0);
    access("R1", 1, 1, 32'h0000_1003, 2'd0);
    wr(1, 0, 32'h0000_003C);
    access("R1", 1, 0, 32'h0000_1000, 2'd0);

    // R2: 8-byte region from an unaligned address word
    wr(0, 0, 32'h0000_1005);
    wr(1, 0, 32'hC000_0038);
    access("R2", 1, 0, 32'h0000_1000, 2'd0);
    access("R2", 1, 0, 32'h0000_1007, 2'd0);
    access("R2", 1, 0, 32'h0000_1008, 2'd0);
    access("R2", 1, 1, 32'h0000_0FFF, 2'd0);

    // R4: partial overlap by wide accesses
    access("R4", 1, 0, 32'h0000_0FFE, 2'd2);
    access("R4", 1, 0, 32'h0000_0FF8, 2'd3);
    access("R4", 1, 1, 32'h0000_0FF9, 2'd3);

    // R5: no hit without a valid access
    access("R5", 0, 0, 32'h0000_1000, 2'd0);

    // R3: broken mask 101100 acts as 100000 (32 bytes)
    wr(0, 1, 32'h0000_2000);
    wr(1, 1, 32'hC000_002C);
    access("R3", 1, 0, 32'h0000_201F, 2'd0);
    access("R3", 1, 0, 32'h0000_2020, 2'd0);
    access("R3", 1, 1, 32'h0000_2010, 2'd1);

    // R6: both units cover the same byte, lowest wins
    wr(0, 1, 32'h0000_1004);
    wr(1, 1, 32'hC000_0038);
    access("R6", 1, 0, 32'h0000_1004, 2'd0);
    wr(1, 0, 32'h0000_0000);
    access("R6", 1, 0, 32'h0000_1004, 2'd0);

    // R8: address written while disarmed is used after arming
    wr(0, 0, 32'h0000_3000);
    access("R8", 1, 1, 32'h0000_3000, 2'd0);
    wr(1, 0, 32'h8000_003F);
    access("R8", 1, 1, 32'h0000_3000, 2'd0);
    access("R8", 1, 1, 32'h0000_1004, 2'd0);
    wr(0, 0, 32'h0000_3001);
    access("R8", 1, 1, 32'h0000_3001, 2'd0);
    access("R8", 1, 1, 32'h0000_3000, 2'd0);

    // Random mix around the configured regions
    for (int it = 0; it < 400; it++) begin
      int u;
      u = int'($urandom_range(NWP - 1));
      if ($urandom_range(3) == 0) begin
        wr(0, u, 32'h0001_0000 + 32'($urandom_range(255)));
      end else if ($urandom_range(3) == 0) begin
        wr(1, u, {2'($urandom_range(3)), 24'h0, 6'($urandom_range(63))});
      end else begin
        int off;
        off = int'($urandom_range(160)) - 80;
        access("R4", 1, bit'($urandom_range(1)), addr_m[u] + 32'(off),
               2'($urandom_range(3)));
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule